// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a circular data buffer of 32 words of 16 bits placed between a processor data port and a card data engine. Either side may write words in and either side may read words out; in practice the transfer direction decides who fills and who drains. A receive transfer fills the buffer from the engine and empties it from the processor bus. A transmit transfer does the reverse.

Two programmable levels watch the fill count. In receive direction, a count above the high-water level asks for service. In transmit direction, a count below the low-water level asks for service. Each direction has its own DMA enable. When the enable is set, the request goes out on a DMA request line. When it is clear, the request sets a status flag that the processor polls or takes as an interrupt. The same event never drives both. A small configuration register holds the two levels and the two enables. The request outputs are worked out from registered state with combinational logic, so they follow every push, pop and configuration write one clock edge later.

Top module: `dma_thresh_fifo`

## Requirements
- R1: After a synchronous active-low reset, the fill count is 0, both DMA enables are off, the low-water level is 0, the high-water level is 31, and the configuration readback is 0x1F00.
- R2: Configuration word layout. Bit 15 is the receive DMA enable. Bits 12:8 are the high-water level. Bit 7 is the transmit DMA enable. Bits 4:0 are the low-water level. The other bits are ignored on write and read back as 0. Writing 0xFFFF therefore reads back 0x9F9F.
- R3: Words leave in the order they entered, including across pointer wrap. The oldest word is shown on the head output while the count is nonzero. An accepted push raises the count by one at the next edge, and an accepted pop lowers it by one.
- R4: A push while the count is 32 is discarded. The count stays at 32 and the stored words are unchanged.
- R5: A pop while the count is 0 has no effect, and the count stays 0.
- R6: In receive direction (dir_rx=1), when the count is greater than the high-water level, rx_dreq is 1 if the receive DMA enable is set, and rx_flag is 1 otherwise. When the count is not above the level, both are 0.
- R7: In transmit direction (dir_rx=0), when the count is less than the low-water level, tx_dreq is 1 if the transmit DMA enable is set, and tx_flag is 1 otherwise. When the count is not below the level, both are 0.
- R8: With xfer_active=0 and the count at 0, all four of rx_flag, tx_flag, rx_dreq and tx_dreq are 0, whatever the levels are.
- R9: A flag and the DMA request of the same direction are never high together. Setting a DMA enable clears that direction's flag from the edge that writes the enable.
- R10: A push and a pop in the same cycle, with the count neither 0 nor 32, both take effect and the count does not change. When the bus and the engine both push in one cycle, a single word is stored and it is the bus word. A pop from either side removes one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Configuration readback |
| xfer_active | input | 1 | A block transfer is in progress |
| dir_rx | input | 1 | 1 = receive (card to processor), 0 = transmit |
| bus_wr | input | 1 | Processor pushes a word |
| bus_wdata | input | 16 | Processor push data |
| bus_rd | input | 1 | Processor pops the head word |
| eng_wr | input | 1 | Engine pushes a word |
| eng_wdata | input | 16 | Engine push data |
| eng_rd | input | 1 | Engine pops the head word |
| head_data | output | 16 | Oldest stored word |
| fill_count | output | 6 | Number of stored words, 0 to 32 |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_flag | output | 1 | Receive service status flag |
| tx_flag | output | 1 | Transmit service status flag |

## Verification
Every result of this block is due exactly one rising edge after its cause. Push, pop and configuration writes are all registered, and the count, head word, readback, flags and requests come out of that state through logic with no further stage. The bench drives each stimulus just after a falling edge and lets one rising edge pass. At the next falling edge it compares every output against a behavioural queue model that has applied the same stimulus. No output is read in the cycle of its own stimulus, and none is read two edges late.

// File: rtl/tfifo_pkg.sv
// Package: shared constants for the threshold FIFO.
// Holds the configuration word bit positions, which software decodes and
// which therefore stay fixed, and the transfer direction encoding.
package tfifo_pkg;
    localparam int CFG_W        = 16;
    localparam int CFG_RXEN_BIT = 15;
    localparam int CFG_HI_LSB   = 8;
    localparam int CFG_TXEN_BIT = 7;
    localparam int CFG_LO_LSB   = 0;
    localparam int LVL_MAX_W    = 5;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/tfifo_cfg.sv
// Module: tfifo_cfg
// Holds the buffer configuration: two DMA enables, high-water level and
// low-water level. Assumes LVL_W <= 5 so that the level fields fit their
// slots in the 16-bit word. The high-water level resets to all ones.
module tfifo_cfg
    import tfifo_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             rx_dma_en,
    output logic             tx_dma_en,
    output logic [LVL_W-1:0] hi_lvl,
    output logic [LVL_W-1:0] lo_lvl,
    output logic [CFG_W-1:0] rd_data
);

    // Configuration register update on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dma_en <= 1'b0;
            tx_dma_en <= 1'b0;
            hi_lvl    <= '1;
            lo_lvl    <= '0;
        end else if (wr_en) begin
            rx_dma_en <= wr_data[CFG_RXEN_BIT];
            tx_dma_en <= wr_data[CFG_TXEN_BIT];
            hi_lvl    <= wr_data[CFG_HI_LSB +: LVL_W];
            lo_lvl    <= wr_data[CFG_LO_LSB +: LVL_W];
        end
    end

    // Readback assembly with unused bits held at zero.
    always_comb begin
        rd_data                       = '0;
        rd_data[CFG_RXEN_BIT]         = rx_dma_en;
        rd_data[CFG_TXEN_BIT]         = tx_dma_en;
        rd_data[CFG_HI_LSB +: LVL_W]  = hi_lvl;
        rd_data[CFG_LO_LSB +: LVL_W]  = lo_lvl;
    end

endmodule

// File: rtl/tfifo_store.sv
// Module: tfifo_store
// Circular word store with read pointer, write pointer and fill count.
// A push is refused when full; a pop is refused when empty. The head output
// always shows the word at the read pointer, stale or not.
module tfifo_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic             push_ok;
    logic             pop_ok;

    // Accept decisions from current occupancy.
    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        rdata   = mem[rd_ptr];
    end

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and count update with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: occupancy never exceeds the depth.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R4: a lone push into a full store leaves it full.
    a_r4_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == FULL_CNT));

    // R5: a lone pop from an empty store leaves it empty.
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (count == '0));

    // R10: simultaneous push and pop keep the count.
    a_r10_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(count));

endmodule

// File: rtl/tfifo_level.sv
// Module: tfifo_level
// Compares the fill count with the two levels and steers each threshold
// event to either a DMA request or a status flag by the direction's DMA
// enable. Everything is quiet while no transfer runs and the store is empty.
module tfifo_level #(
    parameter int CNT_W = 6,
    parameter int LVL_W = 5
) (
    input  logic             xfer_active,
    input  logic             dir_rx,
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] hi_lvl,
    input  logic [LVL_W-1:0] lo_lvl,
    input  logic             rx_dma_en,
    input  logic             tx_dma_en,
    output logic             rx_dreq,
    output logic             tx_dreq,
    output logic             rx_flag,
    output logic             tx_flag
);

    logic live;
    logic rx_hit;
    logic tx_hit;

    // Threshold detection per direction.
    always_comb begin
        live   = xfer_active || (count != '0);
        rx_hit = live && dir_rx  && (count > CNT_W'(hi_lvl));
        tx_hit = live && !dir_rx && (count < CNT_W'(lo_lvl));
    end

    // Route each event to DMA request or status flag.
    always_comb begin
        rx_dreq = rx_hit && rx_dma_en;
        rx_flag = rx_hit && !rx_dma_en;
        tx_dreq = tx_hit && tx_dma_en;
        tx_flag = tx_hit && !tx_dma_en;
    end

endmodule

// File: rtl/dma_thresh_fifo.sv
// Module: dma_thresh_fifo (top)
// Threshold FIFO between processor bus and card engine. Either side may
// push or pop; when both push in one cycle the bus word is taken. Assumes
// DEPTH is 32 so that the 5-bit level fields span the full range.
module dma_thresh_fifo
    import tfifo_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1,
    localparam int LVL_W = PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             xfer_active,
    input  logic             dir_rx,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_rd,
    input  logic             eng_wr,
    input  logic [WIDTH-1:0] eng_wdata,
    input  logic             eng_rd,
    output logic [WIDTH-1:0] head_data,
    output logic [CNT_W-1:0] fill_count,
    output logic             rx_dreq,
    output logic             tx_dreq,
    output logic             rx_flag,
    output logic             tx_flag
);

    logic             push;
    logic             pop;
    logic [WIDTH-1:0] push_data;
    logic             rx_dma_en;
    logic             tx_dma_en;
    logic [LVL_W-1:0] hi_lvl;
    logic [LVL_W-1:0] lo_lvl;
    logic             st_full;
    logic             st_empty;

    // Merge the two sides into one push and one pop, bus first.
    always_comb begin
        push      = bus_wr || eng_wr;
        push_data = bus_wr ? bus_wdata : eng_wdata;
        pop       = bus_rd || eng_rd;
    end

    tfifo_cfg #(.LVL_W(LVL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_data   (cfg_wdata),
        .rx_dma_en (rx_dma_en),
        .tx_dma_en (tx_dma_en),
        .hi_lvl    (hi_lvl),
        .lo_lvl    (lo_lvl),
        .rd_data   (cfg_rdata)
    );

    tfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (push_data),
        .pop   (pop),
        .rdata (head_data),
        .count (fill_count),
        .full  (st_full),
        .empty (st_empty)
    );

    tfifo_level #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_level (
        .xfer_active (xfer_active),
        .dir_rx      (dir_rx),
        .count       (fill_count),
        .hi_lvl      (hi_lvl),
        .lo_lvl      (lo_lvl),
        .rx_dma_en   (rx_dma_en),
        .tx_dma_en   (tx_dma_en),
        .rx_dreq     (rx_dreq),
        .tx_dreq     (tx_dreq),
        .rx_flag     (rx_flag),
        .tx_flag     (tx_flag)
    );

    // R8: idle and empty means every service output is low.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && st_empty) |-> !(rx_flag || tx_flag || rx_dreq || tx_dreq));

    // R9: a newly set receive DMA enable leaves no receive flag.
    a_r9_rx_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dma_en) |-> !rx_flag);

    // R9: a newly set transmit DMA enable leaves no transmit flag.
    a_r9_tx_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_dma_en) |-> !tx_flag);

    // R6: receive threshold with DMA off raises the flag.
    a_r6_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rx && !rx_dma_en && (fill_count > CNT_W'(hi_lvl))) |-> rx_flag);

    // R7: transmit threshold with DMA on raises the request.
    a_r7_tx_dreq: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rx && tx_dma_en && xfer_active && (fill_count < CNT_W'(lo_lvl))) |-> tx_dreq);

endmodule

// File: tb/sim_dma_thresh_fifo.sv
`timescale 1ns/1ps
module sim_dma_thresh_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        xfer_active = 1'b0;
    logic        dir_rx = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        eng_wr = 1'b0;
    logic [15:0] eng_wdata = '0;
    logic        eng_rd = 1'b0;
    logic [15:0] head_data;
    logic [5:0]  fill_count;
    logic        rx_dreq, tx_dreq, rx_flag, tx_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int q[$];
    int m_rxen, m_txen, m_hi, m_lo;

    always #4 clk = ~clk;

    dma_thresh_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xfer_active(xfer_active), .dir_rx(dir_rx),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .eng_wr(eng_wr), .eng_wdata(eng_wdata), .eng_rd(eng_rd),
        .head_data(head_data), .fill_count(fill_count),
        .rx_dreq(rx_dreq), .tx_dreq(tx_dreq), .rx_flag(rx_flag), .tx_flag(tx_flag)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Model update for one rising edge, using the inputs held over it.
    task automatic model_edge();
        bit pu, po;
        if (!rst_n) begin
            q.delete();
            m_rxen = 0; m_txen = 0; m_hi = 31; m_lo = 0;
            return;
        end
        if (cfg_we) begin
            m_rxen = cfg_wdata[15];
            m_hi   = cfg_wdata[12:8];
            m_txen = cfg_wdata[7];
            m_lo   = cfg_wdata[4:0];
        end
        pu = (bus_wr || eng_wr) && (q.size() < 32);
        po = (bus_rd || eng_rd) && (q.size() > 0);
        if (po) void'(q.pop_front());
        if (pu) q.push_back(bus_wr ? int'(bus_wdata) : int'(eng_wdata));
    endtask

    // Full comparison of all outputs against the model.
    task automatic compare();
        int n;
        bit live, rxh, txh;
        n = q.size();
        live = xfer_active || (n != 0);
        rxh = live && dir_rx && (n > m_hi);
        txh = live && !dir_rx && (n < m_lo);
        chk("R3 count", fill_count, n);
        if (n > 0) chk("R3 head", head_data, q[0]);
        chk("R2 cfg readback", cfg_rdata,
            (m_rxen << 15) | (m_hi << 8) | (m_txen << 7) | m_lo);
        chk("R6 rx_dreq", rx_dreq, rxh && m_rxen);
        chk("R6 rx_flag", rx_flag, rxh && !m_rxen);
        chk("R7 tx_dreq", tx_dreq, txh && m_txen);
        chk("R7 tx_flag", tx_flag, txh && !m_txen);
        chk("R9 exclusive", (rx_flag && rx_dreq) || (tx_flag && tx_dreq), 0);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        cfg_we = 0; bus_wr = 0; bus_rd = 0; eng_wr = 0; eng_rd = 0;
    endtask

    task automatic set_cfg(int v);
        cfg_we = 1; cfg_wdata = 16'(v); cyc(); quiet();
    endtask

    task automatic bpush(int v);
        bus_wr = 1; bus_wdata = 16'(v); cyc(); quiet();
    endtask

    task automatic epush(int v);
        eng_wr = 1; eng_wdata = 16'(v); cyc(); quiet();
    endtask

    task automatic bpop();
        bus_rd = 1; cyc(); quiet();
    endtask

    task automatic epop();
        eng_rd = 1; cyc(); quiet();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1: reset values
        chk("R1 reset count", fill_count, 0);
        chk("R1 reset cfg", cfg_rdata, 16'h1F00);

        // R2: unused bits ignored
        set_cfg(16'hFFFF);
        chk("R2 all-ones readback", cfg_rdata, 16'h9F9F);

        // R8: idle, empty, transmit, low level 5
        xfer_active = 0; dir_rx = 0;
        set_cfg(16'h0005);
        chk("R8 quiet flags", {rx_flag, tx_flag, rx_dreq, tx_dreq}, 0);

        // R7: transmit flag below low level 4, DMA off
        set_cfg(16'h0004);
        xfer_active = 1;
        cyc();
        chk("R7 tx flag at count 0", tx_flag, 1);
        for (int i = 0; i < 5; i++) bpush(16'h1000 + i);
        chk("R7 tx flag clear at count 5", tx_flag, 0);
        epop(); epop();
        chk("R7 tx flag at count 3", tx_flag, 1);
        // R9: enabling transmit DMA moves event to the request
        set_cfg(16'h0084);
        chk("R9 tx flag cleared by enable", tx_flag, 0);
        chk("R9 tx dreq raised", tx_dreq, 1);

        // R4 and R3: fill to 32 with wrap, overflow discarded
        set_cfg(16'h1F00);
        while (q.size() < 32) bpush(16'h2000 + q.size());
        chk("R4 full count", fill_count, 32);
        bpush(16'hDEAD);
        chk("R4 push on full discarded", fill_count, 32);
        chk("R4 head unchanged", head_data, 16'h1002);
        // R10: push and pop on full: pop only
        bus_wr = 1; bus_wdata = 16'hBEEF; eng_rd = 1; cyc(); quiet();
        chk("R10 push refused while full", fill_count, 31);
        while (q.size() > 0) epop();

        // R5: pop on empty
        bpop();
        chk("R5 pop on empty", fill_count, 0);
        eng_rd = 1; cyc(); quiet();
        chk("R5 engine pop on empty", fill_count, 0);

        // R6: receive direction, high level 8, DMA off then on
        dir_rx = 1;
        set_cfg(16'h0800);
        for (int i = 0; i < 9; i++) epush(16'h3000 + i);
        chk("R6 rx flag above level", rx_flag, 1);
        bpop();
        chk("R6 rx flag at level", rx_flag, 0);
        epush(16'h3100);
        set_cfg(16'h8800);
        chk("R9 rx flag cleared by enable", rx_flag, 0);
        chk("R6 rx dreq raised", rx_dreq, 1);

        // R10: simultaneous push and pop; dual push takes bus word
        eng_wr = 1; eng_wdata = 16'h4444; bus_rd = 1; cyc(); quiet();
        chk("R10 count kept", fill_count, 9);
        bus_wr = 1; bus_wdata = 16'h5555; eng_wr = 1; eng_wdata = 16'h6666; cyc(); quiet();
        chk("R10 dual push adds one", fill_count, 10);
        while (q.size() > 1) bpop();
        chk("R10 bus word kept", head_data, 16'h5555);
        bpop();

        // R3: long streaming with wrap, interleaved
        dir_rx = 0;
        for (int i = 0; i < 200; i++) begin
            bus_wr = 1; bus_wdata = 16'(i * 7);
            eng_rd = (i % 3 != 0);
            cyc(); quiet();
        end
        while (q.size() > 0) epop();
        xfer_active = 0;
        cyc();
        chk("R8 quiet at end", {rx_flag, tx_flag, rx_dreq, tx_dreq}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule